// File: doc/BRIEF.md
# Instruction prefix register unit

This unit holds a short-lived 16-bit prefix word. A processor core writes it just before an instruction, and it widens that one following instruction. While the prefix is live, its low byte goes out as a high-order data extension. The 3-bit index used on the write picks the register banks that the instruction's short source and destination fields reach.

Once the instruction that uses the prefix has executed, the word returns to zero and the bank selection returns to index 0. In that default state, sources can reach registers 0h to Fh and destinations can reach 0h to 7h. The core marks instruction boundaries with an execute-advance strobe. While that strobe is low (a stall), the prefix and its banks are held unchanged. The stored word can be read back at any time, and reading it does not change it.

Top module: `pfx_unit`

## Requirements
- R1: After reset the stored word reads 0000h, `pfx_valid` is 0, `pfx_byte` is 00h, `src_addr` is {0, `src_field`} and `dst_addr` is {00, `dst_field`}.
- R2: A write (`wr_en`=1) is visible from the next cycle: `rd_data` equals the written word and `pfx_valid` is 1.
- R3: While a prefix is live and `adv` is 0 with no new write, the word, the bank selection and `pfx_valid` stay unchanged.
- R4: The first cycle with `adv`=1 after a write, when it carries no new write, is the one instruction that uses the prefix. From the next cycle the word reads 0000h, `pfx_valid` is 0 and both banks are back to index 0.
- R5: `pfx_byte` carries bits [7:0] of the live word, and bits [15:8] are readable on `rd_data` only.
- R6: Source bank is `wr_idx` bit 0. While the prefix is live, `src_addr` = {`wr_idx`[0], `src_field`[3:0]}, so 0 reaches 0h–Fh and 1 reaches 10h–1Fh.
- R7: Destination group is `wr_idx` bits [2:1]. While the prefix is live, `dst_addr` = {`wr_idx`[2:1], `dst_field`[2:0]}, so 00→0h–7h, 01→8h–Fh, 10→10h–17h and 11→18h–1Fh.
- R8: All eight index values address one and the same 16-bit word, so each write replaces the whole word whatever its index.
- R9: A write in the same cycle as the expiry of a live prefix wins: the new word and index are live in the next cycle and `pfx_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Prefix write strobe |
| wr_idx | input | 3 | Write index; selects the register banks |
| wr_data | input | 16 | Prefix word to store |
| adv | input | 1 | Execute-advance strobe, high on instruction boundaries |
| src_field | input | 4 | Source field of the current instruction |
| dst_field | input | 3 | Destination field of the current instruction |
| rd_data | output | 16 | Current stored word |
| pfx_byte | output | 8 | High-order data extension byte |
| pfx_valid | output | 1 | A written prefix is in effect |
| src_addr | output | 5 | Full source register address |
| dst_addr | output | 5 | Full destination register address |

## Verification
Directed runs cover four timing cases: a write followed by a stall, a write followed at once by an advance, two writes back to back, and a write on the very cycle that consumes the previous prefix. Together they separate a prefix that expires too early, too late or never, and they show whether a new write beats expiry. A sweep over all eight index values, each with a word whose upper and lower bytes differ, separates the source bank bit from the destination group bits and shows that there is one shared word. Random mixes of writes, advances and field values are then compared with a bench model to catch any interaction the directed cases miss.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   localparam int unsigned PFX_DATA_W_DEF = 16;
   localparam int unsigned PFX_EXT_W_DEF  = 8;
   localparam int unsigned PFX_IDX_W_DEF  = 3;
   localparam int unsigned PFX_SRCF_W_DEF = 4;
   localparam int unsigned PFX_DSTF_W_DEF = 3;

   // destination address width grows by the index bits above the source bank bit
   function automatic int unsigned dst_addr_w(input int unsigned dstf_w, input int unsigned idx_w);
      return dstf_w + idx_w - 1;
   endfunction
endpackage

// File: rtl/pfx_store.sv
module pfx_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              adv,
   output logic [DATA_W-1:0] word_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic              live_q
);
   logic expire;
   assign expire = live_q & adv & ~wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
         live_q <= 1'b0;
      end else if (wr_en) begin
         word_q <= wr_data;
         idx_q  <= wr_idx;
         live_q <= 1'b1;
      end else if (expire) begin
         word_q <= '0;
         idx_q  <= '0;
         live_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pfx_addr_ext.sv
module pfx_addr_ext #(
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned SRCF_W = 4,
   parameter int unsigned DSTF_W = 3,
   localparam int unsigned SRCA_W = SRCF_W + 1,
   localparam int unsigned DSTA_W = DSTF_W + IDX_W - 1
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [SRCF_W-1:0] src_field,
   input  logic [DSTF_W-1:0] dst_field,
   output logic [SRCA_W-1:0] src_addr,
   output logic [DSTA_W-1:0] dst_addr
);
   assign src_addr = {idx[0], src_field};

   generate
      if (IDX_W > 1) begin : g_dst_banked
         assign dst_addr = {idx[IDX_W-1:1], dst_field};
      end else begin : g_dst_flat
         assign dst_addr = dst_field;
      end
   endgenerate
endmodule

// File: rtl/pfx_unit.sv
module pfx_unit #(
   parameter int unsigned DATA_W = pfx_pkg::PFX_DATA_W_DEF,
   parameter int unsigned EXT_W  = pfx_pkg::PFX_EXT_W_DEF,
   parameter int unsigned IDX_W  = pfx_pkg::PFX_IDX_W_DEF,
   parameter int unsigned SRCF_W = pfx_pkg::PFX_SRCF_W_DEF,
   parameter int unsigned DSTF_W = pfx_pkg::PFX_DSTF_W_DEF,
   localparam int unsigned SRCA_W = SRCF_W + 1,
   localparam int unsigned DSTA_W = pfx_pkg::dst_addr_w(DSTF_W, IDX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              adv,
   input  logic [SRCF_W-1:0] src_field,
   input  logic [DSTF_W-1:0] dst_field,
   output logic [DATA_W-1:0] rd_data,
   output logic [EXT_W-1:0]  pfx_byte,
   output logic              pfx_valid,
   output logic [SRCA_W-1:0] src_addr,
   output logic [DSTA_W-1:0] dst_addr
);
   generate
      if (EXT_W == 0 || EXT_W > DATA_W) begin : g_bad_ext
         $error("pfx_unit: EXT_W must be 1..DATA_W");
      end
      if (IDX_W == 0) begin : g_bad_idx
         $error("pfx_unit: IDX_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic              live_q;

   pfx_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .adv(adv),
      .word_q(word_q), .idx_q(idx_q), .live_q(live_q)
   );

   pfx_addr_ext #(.IDX_W(IDX_W), .SRCF_W(SRCF_W), .DSTF_W(DSTF_W)) addr_i (
      .idx(idx_q), .src_field(src_field), .dst_field(dst_field),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );

   assign rd_data   = word_q;
   assign pfx_byte  = word_q[EXT_W-1:0];
   assign pfx_valid = live_q;
endmodule

// File: rtl/pfx_unit_chk.sv
module pfx_unit_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned EXT_W  = 8,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned SRCF_W = 4,
   parameter int unsigned DSTF_W = 3,
   localparam int unsigned SRCA_W = SRCF_W + 1,
   localparam int unsigned DSTA_W = DSTF_W + IDX_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              adv,
   input logic [DATA_W-1:0] rd_data,
   input logic [EXT_W-1:0]  pfx_byte,
   input logic              pfx_valid,
   input logic [SRCA_W-1:0] src_addr,
   input logic [DSTA_W-1:0] dst_addr
);
   assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (pfx_valid && rd_data == $past(wr_data)));

   assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_valid && !adv && !wr_en) |=> (pfx_valid && $stable(rd_data) && $stable(src_addr[SRCA_W-1])));

   assert_expiry_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_valid && adv && !wr_en) |=> (!pfx_valid && rd_data == '0));

   assert_idle_byte_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pfx_valid |-> (pfx_byte == '0 && src_addr[SRCA_W-1] == 1'b0));

   assert_src_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (src_addr[SRCA_W-1] == $past(wr_idx[0])));

   generate
      if (IDX_W > 1) begin : g_dst_chk
         assert_dst_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (dst_addr[DSTA_W-1:DSTF_W] == $past(wr_idx[IDX_W-1:1])));
         assert_idle_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !pfx_valid |-> (dst_addr[DSTA_W-1:DSTF_W] == '0));
      end
   endgenerate

   assert_overlap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_valid && adv && wr_en) |=> pfx_valid);
endmodule

bind pfx_unit pfx_unit_chk #(
   .DATA_W(DATA_W), .EXT_W(EXT_W), .IDX_W(IDX_W), .SRCF_W(SRCF_W), .DSTF_W(DSTF_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .adv(adv), .rd_data(rd_data), .pfx_byte(pfx_byte), .pfx_valid(pfx_valid),
   .src_addr(src_addr), .dst_addr(dst_addr)
);

// File: tb/pfx_unit_tb_top.sv
module pfx_unit_tb_top;
   localparam time CLK_P = 8ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic        adv = 1'b0;
   logic [3:0]  src_field = '0;
   logic [2:0]  dst_field = '0;
   logic [15:0] rd_data;
   logic [7:0]  pfx_byte;
   logic        pfx_valid;
   logic [4:0]  src_addr;
   logic [4:0]  dst_addr;

   int unsigned n_checks = 0;
   int unsigned n_fails  = 0;

   logic [15:0] m_word = '0;
   logic [2:0]  m_idx  = '0;
   logic        m_live = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pfx_unit dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .adv(adv), .src_field(src_field), .dst_field(dst_field),
      .rd_data(rd_data), .pfx_byte(pfx_byte), .pfx_valid(pfx_valid),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );

   function automatic logic [4:0] exp_src(input logic [2:0] idx, input logic [3:0] f);
      return {idx[0], f};
   endfunction

   function automatic logic [4:0] exp_dst(input logic [2:0] idx, input logic [2:0] f);
      return {idx[2:1], f};
   endfunction

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "rd_data",   rd_data,                m_word);
      chk(tag, "pfx_valid", {15'd0, pfx_valid},     {15'd0, m_live});
      chk(tag, "pfx_byte",  {8'd0, pfx_byte},       {8'd0, m_word[7:0]});
      chk(tag, "src_addr",  {11'd0, src_addr},      {11'd0, exp_src(m_idx, src_field)});
      chk(tag, "dst_addr",  {11'd0, dst_addr},      {11'd0, exp_dst(m_idx, dst_field)});
   endtask

   // drive one cycle: inputs set after a falling edge, model follows the rising edge
   task automatic step(input logic w, input logic [2:0] i, input logic [15:0] d, input logic a,
                       input logic [3:0] sf, input logic [2:0] df);
      wr_en = w; wr_idx = i; wr_data = d; adv = a; src_field = sf; dst_field = df;
      @(posedge clk);
      if (w) begin
         m_word = d; m_idx = i; m_live = 1'b1;
      end else if (m_live && a) begin
         m_word = '0; m_idx = '0; m_live = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      src_field = 4'hB; dst_field = 3'h5;
      #1;
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // write idx 5 (src bank 1, dst group 10), then stall
      step(1'b1, 3'd5, 16'hA5C3, 1'b1, 4'h3, 3'h2);
      check_all("R2");
      chk("R5", "upper byte readable", {8'd0, rd_data[15:8]}, 16'h00A5);
      chk("R6", "src bank", {11'd0, src_addr}, 16'h0013);
      chk("R7", "dst group", {11'd0, dst_addr}, 16'h0012);
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 3'd0, 16'hFFFF, 1'b0, 4'(k), 3'(k));
         check_all("R3");
      end
      // consuming instruction
      step(1'b0, 3'd7, 16'h1234, 1'b1, 4'hF, 3'h7);
      check_all("R4");
      chk("R4", "idle src addr", {11'd0, src_addr}, 16'h000F);
      chk("R4", "idle dst addr", {11'd0, dst_addr}, 16'h0007);
      step(1'b0, 3'd0, 16'h0, 1'b1, 4'h1, 3'h1);
      check_all("R4");

      // back-to-back writes, second lands on the consuming cycle
      step(1'b1, 3'd2, 16'h00FF, 1'b1, 4'h0, 3'h0);
      check_all("R2");
      step(1'b1, 3'd7, 16'h7E81, 1'b1, 4'h9, 3'h6);
      check_all("R9");
      chk("R9", "new word wins", rd_data, 16'h7E81);
      chk("R9", "still live", {15'd0, pfx_valid}, 16'h0001);
      chk("R9", "new dst group", {11'd0, dst_addr}, 16'h001E);
      step(1'b0, 3'd0, 16'h0, 1'b1, 4'h9, 3'h6);
      check_all("R4");

      // every index hits the same word
      for (int i = 0; i < 8; i++) begin
         logic [15:0] d;
         d = {8'(8'h10 * i + 1), 8'(8'hF0 - i)};
         step(1'b1, 3'(i), d, 1'b0, 4'(i * 3), 3'(i));
         check_all("R8");
         chk("R8", "shared word", rd_data, d);
         chk("R6", "src bank sweep", {15'd0, src_addr[4]}, {15'd0, 1'(i & 1)});
         chk("R7", "dst group sweep", {14'd0, dst_addr[4:3]}, {14'd0, 2'(i >> 1)});
      end
      step(1'b0, 3'd0, 16'h0, 1'b1, 4'h0, 3'h0);
      check_all("R4");

      // random mix against the model
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 4) == 0, 3'($urandom), 16'($urandom), ($urandom % 3) != 0,
              4'($urandom), 3'($urandom));
         check_all("R2");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule